// File: doc/BRIEF.md
# Indexed Control Register Access Unit

This block is the part of a 16C550-style UART host register interface that reaches a bank of hidden control registers through the scratchpad location. Software writes an 8-bit index into the scratchpad and then writes a byte to the indexed-port address. That byte lands in the control register the index selects. The indexed bank cannot be read through the plain write sequence. A read-enable bit held in control register 0 opens it. A second bit in the same register opens a small window of additional status bytes, which are selected by indices with bit 7 set.

All indexed traffic depends on the last byte written to the line control register (LCR). While that byte is the enhanced-mode key 0xBF, the indexed port address reaches a single enhanced register instead of the bank. The bank's contents drive the rest of the UART through a flat output bus. The status window is fed from the serial side through `ast_in`.

Top module: `icr_access_unit`

## Requirements
- R1: After reset, LCR, the scratchpad, every control register and the enhanced register read as zero. Both enable bits are therefore clear, and a read of the indexed port (address 5) returns `lsr_in`.
- R2: The scratchpad (address 7) and LCR (address 3) return the last byte written to them in any mode.
- R3: With LCR not equal to 0xBF, a write to address 5 stores the byte into control register number `scratchpad`. The new value shows on `idx_regs_o[8*i +: 8]` one clock after the write edge.
- R4: With LCR equal to 0xBF, a write to address 5 goes to the enhanced register (`enh_o`) and leaves `idx_regs_o` unchanged.
- R5: An index of NUM_IDX (16) or more leaves `idx_regs_o` unchanged on a write. Such an index reads back as zero when the bank is readable.
- R6: With LCR not 0xBF and control register 0 bit 6 clear, a read of address 5 returns `lsr_in`. This applies unless the status window is selected and open.
- R7: With control register 0 bit 6 set and LCR not 0xBF, a read of address 5 returns control register number `scratchpad`.
- R8: With control register 0 bit 7 set and scratchpad bit 7 set, a read of address 5 returns status byte `scratchpad[6:0]` of `ast_in`, where byte k is `ast_in[8k +: 8]`. It returns zero for k of NUM_AST (4) or more. With bit 7 clear the window stays closed.
- R9: With LCR equal to 0xBF, a read of address 5 returns the enhanced register.
- R10: Writing any LCR value other than 0xBF restores indexed access, and the bank keeps its contents across the key mode.
- R11: `rdata` is zero when `rd_en` is low, and for any address other than 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe; qualifies rdata |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |
| lsr_in | input | 8 | Standard status byte normally mapped at address 5 |
| ast_in | input | 32 | Additional status bytes, byte k at bits 8k+7:8k |
| lcr_o | output | 8 | Current line control value |
| enh_o | output | 8 | Enhanced register at address 5 |
| idx_regs_o | output | 128 | Control bank, register i at bits 8i+7:8i |

## Verification
The assertions assume that a write strobe lasts one cycle and that `addr` and `wdata` are settled at the clock edge that samples them. They also assume that `lsr_in` and `ast_in` do not change in a cycle where a read result is compared. The bench drives every input at the falling edge, pulses `wr_en` for exactly one clock, and holds the status inputs constant between reads. It samples `rdata` a short time after setting the address, and only while `rd_en` is high.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int DW = 8;
  localparam logic [2:0] A_LCR = 3'd3;
  localparam logic [2:0] A_ICR = 3'd5;
  localparam logic [2:0] A_SPR = 3'd7;
  localparam logic [7:0] LCR_KEY = 8'hBF;
  localparam int RDEN_BIT  = 6;
  localparam int ASTEN_BIT = 7;

  typedef enum logic [1:0] {SRC_STD, SRC_ENH, SRC_IDX, SRC_AST} rsrc_t;

  // true when the index names an implemented bank entry
  function automatic logic idx_in_bank(input logic [7:0] idx, input int n);
    return int'(idx) < n;
  endfunction

  // true when the index points at the status window
  function automatic logic idx_is_status(input logic [7:0] idx);
    return idx[7];
  endfunction

  function automatic logic key_active(input logic [7:0] lcr);
    return lcr == LCR_KEY;
  endfunction
endpackage

// File: rtl/icr_front.sv
module icr_front
  import icr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] lcr_q,
  output logic [7:0] spr_q,
  output logic [7:0] enh_q,
  output logic       key_mode,
  output logic       idx_wr_evt,
  output logic       enh_wr_evt
);
  logic port_wr;

  always_comb begin
    key_mode   = key_active(lcr_q);
    port_wr    = wr_en && (addr == A_ICR);
    idx_wr_evt = port_wr && !key_mode;
    enh_wr_evt = port_wr && key_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q <= '0;
      spr_q <= '0;
      enh_q <= '0;
    end else begin
      if (wr_en && addr == A_LCR) lcr_q <= wdata;
      if (wr_en && addr == A_SPR) spr_q <= wdata;
      if (enh_wr_evt)             enh_q <= wdata;
    end
  end
endmodule

// File: rtl/icr_bank.sv
module icr_bank
  import icr_pkg::*;
#(
  parameter int NUM_IDX = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [7:0]           idx,
  input  logic [7:0]           wdata,
  output logic [NUM_IDX*8-1:0] regs_flat,
  output logic [7:0]           rd_val
);
  for (genvar k = 0; k < NUM_IDX; k++) begin : g_ent
    localparam logic [7:0] MY_IDX = 8'(k);
    logic [7:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   val_q <= '0;
      else if (wr && idx == MY_IDX) val_q <= wdata;
    end
    assign regs_flat[k*8 +: 8] = val_q;
  end

  always_comb begin
    rd_val = '0;
    if (idx_in_bank(idx, NUM_IDX)) begin
      for (int k = 0; k < NUM_IDX; k++)
        if (idx == 8'(k)) rd_val = regs_flat[k*8 +: 8];
    end
  end
endmodule

// File: rtl/icr_rmux.sv
module icr_rmux
  import icr_pkg::*;
#(
  parameter int NUM_AST = 4
) (
  input  logic                 rd_en,
  input  logic [2:0]           addr,
  input  logic                 key_mode,
  input  logic [7:0]           lcr_q,
  input  logic [7:0]           spr_q,
  input  logic [7:0]           enh_q,
  input  logic [7:0]           bank_val,
  input  logic [7:0]           ctl0,
  input  logic [7:0]           lsr_in,
  input  logic [NUM_AST*8-1:0] ast_in,
  output rsrc_t                src,
  output logic [7:0]           rdata
);
  logic [7:0] ast_val;
  logic [7:0] icr_val;

  always_comb begin
    ast_val = '0;
    for (int k = 0; k < NUM_AST; k++)
      if (spr_q[6:0] == 7'(k)) ast_val = ast_in[k*8 +: 8];
  end

  always_comb begin
    if (key_mode)                                       src = SRC_ENH;
    else if (idx_is_status(spr_q) && ctl0[ASTEN_BIT])   src = SRC_AST;
    else if (ctl0[RDEN_BIT])                            src = SRC_IDX;
    else                                                src = SRC_STD;
    case (src)
      SRC_ENH: icr_val = enh_q;
      SRC_AST: icr_val = ast_val;
      SRC_IDX: icr_val = bank_val;
      default: icr_val = lsr_in;
    endcase
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_LCR:   rdata = lcr_q;
        A_SPR:   rdata = spr_q;
        A_ICR:   rdata = icr_val;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/icr_access_unit.sv
module icr_access_unit
  import icr_pkg::*;
#(
  parameter int NUM_IDX = 16,
  parameter int NUM_AST = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [2:0]           addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic [7:0]           lsr_in,
  input  logic [NUM_AST*8-1:0] ast_in,
  output logic [7:0]           lcr_o,
  output logic [7:0]           enh_o,
  output logic [NUM_IDX*8-1:0] idx_regs_o
);
  logic [7:0] lcr_q, spr_q, enh_q, bank_val;
  logic       key_mode, idx_wr_evt, enh_wr_evt;
  rsrc_t      rd_src;

  icr_front u_front (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lcr_q(lcr_q), .spr_q(spr_q), .enh_q(enh_q), .key_mode(key_mode),
    .idx_wr_evt(idx_wr_evt), .enh_wr_evt(enh_wr_evt)
  );

  icr_bank #(.NUM_IDX(NUM_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(idx_wr_evt), .idx(spr_q), .wdata(wdata),
    .regs_flat(idx_regs_o), .rd_val(bank_val)
  );

  icr_rmux #(.NUM_AST(NUM_AST)) u_rmux (
    .rd_en(rd_en), .addr(addr), .key_mode(key_mode), .lcr_q(lcr_q),
    .spr_q(spr_q), .enh_q(enh_q), .bank_val(bank_val),
    .ctl0(idx_regs_o[7:0]), .lsr_in(lsr_in), .ast_in(ast_in),
    .src(rd_src), .rdata(rdata)
  );

  assign lcr_o = lcr_q;
  assign enh_o = enh_q;
endmodule

// File: rtl/icr_access_chk.sv
module icr_access_chk
  import icr_pkg::*;
#(
  parameter int NUM_IDX = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [2:0]           addr,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic [7:0]           lsr_in,
  input logic [7:0]           lcr_o,
  input logic [7:0]           spr_q,
  input logic [7:0]           enh_o,
  input logic [NUM_IDX*8-1:0] idx_regs_o,
  input logic                 idx_wr_evt,
  input logic                 enh_wr_evt
);
  logic       pend_idx_wr, pend_enh_wr;
  logic [7:0] pend_idx, pend_dat, pend_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_idx_wr <= 1'b0;
      pend_enh_wr <= 1'b0;
      pend_idx    <= '0;
      pend_dat    <= '0;
    end else begin
      pend_idx_wr <= wr_en && addr == A_ICR && lcr_o != LCR_KEY && int'(spr_q) < NUM_IDX;
      pend_enh_wr <= wr_en && addr == A_ICR && lcr_o == LCR_KEY;
      pend_idx    <= spr_q;
      pend_dat    <= wdata;
    end
  end

  always_comb begin
    pend_now = '0;
    for (int k = 0; k < NUM_IDX; k++)
      if (pend_idx == 8'(k)) pend_now = idx_regs_o[k*8 +: 8];
  end

  // R3
  idx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_idx_wr |-> pend_now == pend_dat);

  // R4
  enh_divert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_enh_wr |-> enh_o == pend_dat);

  // R4
  enh_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ICR && lcr_o == LCR_KEY) |=> $stable(idx_regs_o));

  // R5
  oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ICR && int'(spr_q) >= NUM_IDX) |=> $stable(idx_regs_o));

  // R6
  std_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ICR && lcr_o != LCR_KEY && !idx_regs_o[RDEN_BIT]
      && !(spr_q[7] && idx_regs_o[ASTEN_BIT])) |-> rdata == lsr_in);

  // R11
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

  // R4
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idx_wr_evt, enh_wr_evt}));
endmodule

bind icr_access_unit icr_access_chk #(.NUM_IDX(NUM_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .lsr_in(lsr_in), .lcr_o(lcr_o),
  .spr_q(spr_q), .enh_o(enh_o), .idx_regs_o(idx_regs_o),
  .idx_wr_evt(idx_wr_evt), .enh_wr_evt(enh_wr_evt)
);

// File: tb/sim_icr_access_unit.sv
module sim_icr_access_unit;
  localparam int NI = 16;
  localparam int NA = 4;
  localparam logic [2:0] LCR = 3'd3, ICR = 3'd5, SPR = 3'd7;

  typedef struct packed {
    logic       rd;   // 1: read and compare, 0: write
    logic [2:0] a;
    logic [7:0] d;    // write data or expected read data
    logic [3:0] req;  // requirement number for messages
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, SPR, 8'h03, 4'd2},
    '{1'b1, SPR, 8'h03, 4'd2},   // R2 scratchpad readback
    '{1'b0, ICR, 8'h5A, 4'd3},   // R3 store to entry 3
    '{1'b1, ICR, 8'h60, 4'd6},   // R6 enable clear -> lsr_in
    '{1'b0, SPR, 8'h00, 4'd7},
    '{1'b0, ICR, 8'h40, 4'd7},   // open bank reads
    '{1'b0, SPR, 8'h03, 4'd7},
    '{1'b1, ICR, 8'h5A, 4'd7},   // R7 bank read
    '{1'b0, SPR, 8'h20, 4'd5},
    '{1'b0, ICR, 8'h77, 4'd5},
    '{1'b1, ICR, 8'h00, 4'd5},   // R5 unimplemented reads zero
    '{1'b0, SPR, 8'h81, 4'd8},
    '{1'b1, ICR, 8'h00, 4'd8},   // R8 window closed, bank open -> zero
    '{1'b0, SPR, 8'h00, 4'd8},
    '{1'b0, ICR, 8'hC0, 4'd8},
    '{1'b0, SPR, 8'h81, 4'd8},
    '{1'b1, ICR, 8'hB2, 4'd8},   // R8 status byte 1
    '{1'b0, SPR, 8'h85, 4'd8},
    '{1'b1, ICR, 8'h00, 4'd8},   // R8 beyond NUM_AST
    '{1'b0, LCR, 8'hBF, 4'd9},
    '{1'b0, ICR, 8'h33, 4'd9},
    '{1'b1, ICR, 8'h33, 4'd9},   // R9 enhanced register
    '{1'b0, LCR, 8'h03, 4'd10},
    '{1'b0, SPR, 8'h03, 4'd10}
  };

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [7:0]    wdata = '0, rdata, lsr_in = 8'h60, lcr_o, enh_o;
  logic [NA*8-1:0] ast_in = 32'hD4C3B2A1;
  logic [NI*8-1:0] idx_regs_o, snap;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  icr_access_unit #(.NUM_IDX(NI), .NUM_AST(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lsr_in(lsr_in), .ast_in(ast_in),
    .lcr_o(lcr_o), .enh_o(enh_o), .idx_regs_o(idx_regs_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(ICR, v); check("R1 icr after reset", 128'(v), 128'h60);
    rd(SPR, v); check("R1 spr after reset", 128'(v), 128'h00);
    check("R1 bank after reset", idx_regs_o, '0);
    check("R1 enh after reset", 128'(enh_o), 128'h0);
    @(negedge clk); rst_n = 1'b1;
    // R11 no read strobe
    @(negedge clk); addr = SPR; #2 check("R11 rdata without rd_en", 128'(rdata), 128'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) begin
        rd(VECS[i].a, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), 128'(v), 128'(VECS[i].d));
      end else begin
        wr(VECS[i].a, VECS[i].d);
      end
    end

    // R10 bank back after key mode, contents kept
    rd(ICR, v); check("R10 entry 3 after key mode", 128'(v), 128'h5A);
    check("R3 entry 3 on bus", 128'(idx_regs_o[3*8 +: 8]), 128'h5A);
    check("R3 entry 0 on bus", 128'(idx_regs_o[7:0]), 128'hC0);
    rd(LCR, v); check("R2 lcr readback", 128'(v), 128'h03);
    rd(3'd1, v); check("R11 unmapped address", 128'(v), 128'h00);

    // R4 key-mode write leaves bank untouched
    wr(LCR, 8'hBF); snap = idx_regs_o;
    wr(ICR, 8'hE7);
    check("R4 bank stable in key mode", idx_regs_o, snap);
    check("R4 enhanced register", 128'(enh_o), 128'hE7);
    rd(LCR, v); check("R2 lcr key readback", 128'(v), 128'hBF);

    // R5 out-of-range write ignored
    wr(LCR, 8'h00); wr(SPR, 8'h10); snap = idx_regs_o;
    wr(ICR, 8'hAA);
    check("R5 bank stable on index 16", idx_regs_o, snap);
    // R3 last entry
    wr(SPR, 8'h0F); wr(ICR, 8'h9C);
    check("R3 entry 15", 128'(idx_regs_o[15*8 +: 8]), 128'h9C);

    // R6 clearing read enable, lsr change
    wr(SPR, 8'h00); wr(ICR, 8'h00); lsr_in = 8'h21;
    wr(SPR, 8'h0F); rd(ICR, v); check("R6 closed bank gives lsr", 128'(v), 128'h21);
    // R8 window alone, bank closed
    wr(SPR, 8'h00); wr(ICR, 8'h80); wr(SPR, 8'h83);
    rd(ICR, v); check("R8 status byte 3", 128'(v), 128'hD4);
    wr(SPR, 8'h02); rd(ICR, v); check("R6 index below window, bank closed", 128'(v), 128'h21);

    // R1 reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    check("R1 bank after second reset", idx_regs_o, '0);
    rst_n = 1'b1;
    rd(ICR, v); check("R1 enables cleared", 128'(v), 128'h21);
    summary();
  end
endmodule